// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing reference for a two-output pulse-width modulator. A 16-bit counter advances on a tick derived from the module clock through a two-stage prescaler. The counter can count up, count down, count up then down, or stay frozen. Its period comes from a period register that takes writes either directly or through a shadow copy. The shadow copy is transferred when the counter lands on zero.

The block takes control fields that are already decoded and a period write strobe. It produces the counter value, a direction flag, and two single-cycle event strobes: one when the counter lands on zero and one when it lands on the period. A run-mode field can halt the counter on the next tick, halt it when the current cycle ends, or let it run freely. Compare logic and output shaping sit downstream and use these outputs.

Top module: `pwm_tbase`

## Requirements
- R1: While rst_ni is low and after it is released, cnt_o is 0, dir_down_o is 0, zero_o and prd_o are 0, and the active and shadow periods are 0.
- R2: The counter steps once every 2^clk_div_i × F module clocks. F is 1 when hs_div_i is 0 and 2×hs_div_i otherwise.
- R3: With cnt_mode_i = 00 (up), the counter steps 0,1,…,P and then wraps to 0. zero_o pulses when it lands on 0, prd_o pulses when it lands on P, and dir_down_o is 0.
- R4: With cnt_mode_i = 01 (down), the counter steps P,…,1,0 and then reloads P. dir_down_o is 1, and the strobes mark landings on 0 and on P.
- R5: With cnt_mode_i = 10 (up-down), the counter rises to P and falls to 0, reversing at each end. dir_down_o is 1 from the landing on P until the landing on 0.
- R6: With cnt_mode_i = 11 (freeze), cnt_o holds its value and neither strobe fires.
- R7: With prd_imm_i = 0, a write goes to the shadow copy. The active period keeps its old value until the counter next lands on 0, and then takes the shadow value.
- R8: With prd_imm_i = 1, a write sets the active period at once. If the counter is already above the new period, an up-counting counter wraps to 0 on its next step.
- R9: With run_mode_i = 00, the counter does not step on any later tick, and neither strobe fires.
- R10: With run_mode_i = 01, the counter keeps stepping until it lands on 0 and then holds there. It resumes once run_mode_i[1] is set (10 and 11 both run freely).
- R11: With an active period of 0 and the counter running, cnt_o stays 0 and both strobes fire on every tick.
- R12: Each strobe is high for one module clock per tick that causes it, so with a prescale above 1 the strobes are never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_mode_i | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 freeze |
| run_mode_i | input | 2 | Run mode: 00 halt now, 01 halt at cycle end, 1x free run |
| clk_div_i | input | 3 | Power-of-two prescale exponent |
| hs_div_i | input | 3 | Even-multiple prescale field |
| prd_imm_i | input | 1 | 1: period writes go straight to the active period |
| prd_wr_i | input | 1 | Period write strobe |
| prd_data_i | input | 16 | Period write data |
| cnt_o | output | 16 | Counter value |
| zero_o | output | 1 | Counter landed on zero |
| prd_o | output | 1 | Counter landed on the period |
| dir_down_o | output | 1 | 1 while counting down |

## Verification
The bench targets the points where a time base typically goes wrong. The shadow transfer must happen on the landing at zero and not on the write, otherwise the cycle in progress would end at the new period. An immediate write that drops the period below the current count must wrap the counter; a design that compares for equality would run on to 65535. The run-to-cycle-end mode must stop exactly on zero, and a design that ignored it would keep counting. A period of zero must strobe on every tick without the counter leaving zero. The interval between counter steps is measured for several prescale settings, which exposes a divider that uses the fields linearly or treats a zero field as divide-by-zero.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDN   = 2'b10,
    CM_FREEZE = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RM_HALT   = 2'b00,
    RM_ENDCYC = 2'b01,
    RM_FREE0  = 2'b10,
    RM_FREE1  = 2'b11
  } run_mode_e;
endpackage

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc #(
  parameter int CDIV_W = 3,
  parameter int HDIV_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CDIV_W-1:0] clk_div_i,
  input  logic [HDIV_W-1:0] hs_div_i,
  output logic              tick_o
);
  localparam int S1_W = HDIV_W + 1;
  localparam int S2_W = (1 << CDIV_W) - 1;

  logic [S1_W-1:0] s1_q, s1_lim;
  logic [S2_W-1:0] s2_q, s2_lim;
  logic [S2_W:0]   s2_span;
  logic            s1_hit;

  // stage 1: 1 or 2*hs, stage 2: 2^cd
  assign s1_lim  = (hs_div_i == '0) ? '0 : ({hs_div_i, 1'b0} - S1_W'(1));
  assign s2_span = (S2_W+1)'(1) << clk_div_i;
  assign s2_lim  = s2_span[S2_W-1:0] - S2_W'(1);
  assign s1_hit  = (s1_q >= s1_lim);
  assign tick_o  = s1_hit && (s2_q >= s2_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_hit ? '0 : s1_q + S1_W'(1);
      if (s1_hit) s2_q <= tick_o ? '0 : s2_q + S2_W'(1);
    end
  end
endmodule

// File: rtl/pwm_tbase_period.sv
module pwm_tbase_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             imm_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] prd_o
);
  logic [CNT_W-1:0] act_q, shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      shd_q <= '0;
    end else if (wr_i && imm_i) begin
      act_q <= data_i;
      shd_q <= data_i;
    end else begin
      if (wr_i)   shd_q <= data_i;
      if (xfer_i) act_q <= shd_q;
    end
  end

  assign prd_o = act_q;
endmodule

// File: rtl/pwm_tbase_count.sv
module pwm_tbase_count
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic [1:0]       run_mode_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             dir_down_o,
  output logic             adv_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             dir_q, dir_nxt, done_q, run_ok;

  assign run_ok = run_mode_i[1] || ((run_mode_i == RM_ENDCYC) && !done_q);
  assign adv_o  = tick_i && (cnt_mode_i != CM_FREEZE) && run_ok;
  assign wrap_o = adv_o && (nxt == '0);

  always_comb begin
    nxt     = cnt_q;
    dir_nxt = dir_q;
    unique case (cnt_mode_i)
      CM_UP: begin
        nxt     = (cnt_q >= prd_i) ? '0 : cnt_q + ONE;
        dir_nxt = 1'b0;
      end
      CM_DOWN: begin
        nxt     = (cnt_q == '0 || cnt_q > prd_i) ? prd_i : cnt_q - ONE;
        dir_nxt = 1'b1;
      end
      CM_UPDN: begin
        if (prd_i == '0)        nxt = '0;
        else if (dir_q)         nxt = (cnt_q > prd_i) ? prd_i :
                                      (cnt_q == '0) ? ONE : cnt_q - ONE;
        else                    nxt = (cnt_q >= prd_i) ? prd_i - ONE : cnt_q + ONE;
        if (prd_i != '0 && nxt == prd_i) dir_nxt = 1'b1;
        else if (nxt == '0)              dir_nxt = 1'b0;
        else                             dir_nxt = (nxt < cnt_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      zero_o <= 1'b0;
      prd_o  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      zero_o <= adv_o && (nxt == '0);
      prd_o  <= adv_o && (nxt == prd_i);
      if (adv_o) begin
        cnt_q <= nxt;
        dir_q <= dir_nxt;
      end
      if (run_mode_i[1])                                  done_q <= 1'b0;
      else if (wrap_o && (run_mode_i == RM_ENDCYC))       done_q <= 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase #(
  parameter int CNT_W  = 16,
  parameter int CDIV_W = 3,
  parameter int HDIV_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cnt_mode_i,
  input  logic [1:0]        run_mode_i,
  input  logic [CDIV_W-1:0] clk_div_i,
  input  logic [HDIV_W-1:0] hs_div_i,
  input  logic              prd_imm_i,
  input  logic              prd_wr_i,
  input  logic [CNT_W-1:0]  prd_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_o,
  output logic              prd_o,
  output logic              dir_down_o
);
  logic             tick, adv, wrap;
  logic [CNT_W-1:0] prd_act;

  pwm_tbase_presc #(.CDIV_W(CDIV_W), .HDIV_W(HDIV_W)) u_presc (
    .clk_i, .rst_ni, .clk_div_i, .hs_div_i, .tick_o(tick)
  );

  pwm_tbase_period #(.CNT_W(CNT_W)) u_prd (
    .clk_i, .rst_ni, .wr_i(prd_wr_i), .imm_i(prd_imm_i),
    .data_i(prd_data_i), .xfer_i(wrap), .prd_o(prd_act)
  );

  pwm_tbase_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_mode_i, .run_mode_i,
    .prd_i(prd_act), .cnt_o, .zero_o, .prd_o, .dir_down_o,
    .adv_o(adv), .wrap_o(wrap)
  );
endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cnt_mode_i,
  input logic [1:0]       run_mode_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             zero_o,
  input logic             prd_o,
  input logic             dir_down_o,
  input logic [CNT_W-1:0] prd_act,
  input logic             adv
);
  p_zero_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (cnt_o == '0));

  p_prd_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_o |-> (cnt_o == $past(prd_act)));

  p_up_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt_mode_i == 2'b00) |=> !dir_down_o);

  p_down_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt_mode_i == 2'b01) |=> dir_down_o);

  p_freeze_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i == 2'b11) |=> ($stable(cnt_o) && !zero_o && !prd_o));

  p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode_i == 2'b00) |=> ($stable(cnt_o) && !zero_o && !prd_o));

  p_zero_prd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && prd_act == '0) |=> (zero_o && prd_o && cnt_o == '0));
endmodule

bind pwm_tbase pwm_tbase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cnt_mode_i, .run_mode_i, .cnt_o, .zero_o, .prd_o,
  .dir_down_o, .prd_act, .adv
);

// File: tb/sim_pwm_tbase.sv
module sim_pwm_tbase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cnt_mode = 2'b00;
  logic [1:0]  run_mode = 2'b00;
  logic [2:0]  clk_div = '0;
  logic [2:0]  hs_div = '0;
  logic        prd_imm = 1'b0;
  logic        prd_wr = 1'b0;
  logic [15:0] prd_data = '0;
  logic [15:0] cnt;
  logic        zero, prd, dir_down;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm_tbase u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_mode_i(cnt_mode), .run_mode_i(run_mode),
    .clk_div_i(clk_div), .hs_div_i(hs_div), .prd_imm_i(prd_imm),
    .prd_wr_i(prd_wr), .prd_data_i(prd_data), .cnt_o(cnt), .zero_o(zero),
    .prd_o(prd), .dir_down_o(dir_down)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_mode = 2'b00; run_mode = 2'b00;
    clk_div = '0; hs_div = '0; prd_imm = 1'b0; prd_wr = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr_prd(input int val, input bit imm);
    prd_imm = imm; prd_data = 16'(val); prd_wr = 1'b1;
    @(negedge clk);
    prd_wr = 1'b0;
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 cnt", cnt, 0); chk("R1 zero", zero, 0);
    chk("R1 prd", prd, 0); chk("R1 dir", dir_down, 0);
    wr_prd(7, 1); run_mode = 2'b10; step(3);
    rst_n = 1'b0; step(1);
    chk("R1 cnt in reset", cnt, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_up_r3();
    do_reset(); wr_prd(4, 1);
    cnt_mode = 2'b00; run_mode = 2'b10;
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      chk("R3 cnt", cnt, i % 5);
      chk("R3 zero", zero, int'(i % 5 == 0));
      chk("R3 prd", prd, int'(i % 5 == 4));
      chk("R3 dir", dir_down, 0);
    end
  endtask

  task automatic t_down_r4();
    do_reset(); wr_prd(3, 1);
    cnt_mode = 2'b01; run_mode = 2'b10;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk("R4 cnt", cnt, 3 - ((i - 1) % 4));
      chk("R4 dir", dir_down, 1);
      chk("R4 zero", zero, int'((i - 1) % 4 == 3));
      chk("R4 prd", prd, int'((i - 1) % 4 == 0));
    end
  endtask

  task automatic t_updn_r5();
    do_reset(); wr_prd(3, 1);
    cnt_mode = 2'b10; run_mode = 2'b10;
    for (int i = 1; i <= 13; i++) begin
      int k = i % 6;
      @(negedge clk);
      chk("R5 cnt", cnt, (k <= 3) ? k : 6 - k);
      chk("R5 dir", dir_down, int'(k >= 3));
      chk("R5 prd", prd, int'(k == 3));
      chk("R5 zero", zero, int'(k == 0));
    end
  endtask

  task automatic t_freeze_r6();
    do_reset(); wr_prd(9, 1); run_mode = 2'b10; step(2);
    cnt_mode = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 cnt held", cnt, 2);
      chk("R6 no strobe", zero | prd, 0);
    end
    cnt_mode = 2'b00; step(1);
    chk("R6 resume", cnt, 3);
  endtask

  task automatic t_shadow_r7();
    int exp[7] = '{4, 5, 0, 1, 2, 0, 1};
    int eprd[7] = '{0, 1, 0, 0, 1, 0, 0};
    do_reset(); wr_prd(5, 1); run_mode = 2'b10; step(2);
    wr_prd(2, 0);
    chk("R7 cnt after write", cnt, 3);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk("R7 cnt", cnt, exp[i]);
      chk("R7 prd", prd, eprd[i]);
    end
  endtask

  task automatic t_imm_r8();
    int exp2[4] = '{0, 1, 2, 0};
    do_reset(); wr_prd(5, 1); run_mode = 2'b10; step(1);
    wr_prd(3, 1);
    chk("R8 cnt", cnt, 2);
    step(1); chk("R8 cnt at new prd", cnt, 3); chk("R8 prd", prd, 1);
    step(1); chk("R8 wrap", cnt, 0);
    do_reset(); wr_prd(5, 1); run_mode = 2'b10; step(4);
    wr_prd(2, 1);
    chk("R8 above prd", cnt, 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 shrink wrap", cnt, exp2[i]);
    end
  endtask

  task automatic t_halt_r9();
    do_reset(); wr_prd(9, 1); run_mode = 2'b10; step(3);
    run_mode = 2'b00;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 cnt held", cnt, 3);
      chk("R9 no strobe", zero | prd, 0);
    end
  endtask

  task automatic t_endcyc_r10();
    int exp[7] = '{2, 3, 4, 0, 0, 0, 0};
    do_reset(); wr_prd(4, 1); run_mode = 2'b10; step(1);
    run_mode = 2'b01;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk("R10 cnt", cnt, exp[i]);
      chk("R10 zero", zero, int'(i == 3));
    end
    run_mode = 2'b11; step(1);
    chk("R10 resume", cnt, 1);
  endtask

  task automatic t_zero_prd_r11_r12();
    int hits = 0;
    int pairs = 0;
    int last = 0;
    do_reset(); run_mode = 2'b10;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 cnt", cnt, 0);
      chk("R11 both strobes", zero & prd, 1);
    end
    clk_div = 3'd1; step(4);
    last = zero;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hits += zero;
      if (zero && last) pairs++;
      last = zero;
    end
    chk("R12 strobe count", hits, 4);
    chk("R12 back to back", pairs, 0);
  endtask

  task automatic measure(output int gap);
    logic [15:0] v;
    int n;
    v = cnt; n = 0;
    while (cnt == v && n < 4000) begin @(negedge clk); n++; end
    v = cnt; n = 0;
    while (cnt == v && n < 4000) begin @(negedge clk); n++; end
    gap = n;
  endtask

  task automatic t_presc_r2(input int cd, input int hs);
    int gap;
    int exp = (1 << cd) * ((hs == 0) ? 1 : 2 * hs);
    do_reset(); wr_prd(1000, 1); run_mode = 2'b10;
    clk_div = 3'(cd); hs_div = 3'(hs);
    measure(gap); measure(gap);
    chk($sformatf("R2 gap cd=%0d hs=%0d", cd, hs), gap, exp);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_up_r3();
    t_down_r4();
    t_updn_r5();
    t_freeze_r6();
    t_shadow_r7();
    t_imm_r8();
    t_halt_r9();
    t_endcyc_r10();
    t_zero_prd_r11_r12();
    t_presc_r2(0, 0);
    t_presc_r2(1, 2);
    t_presc_r2(2, 0);
    t_presc_r2(0, 3);
    t_presc_r2(3, 7);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule